// File: doc/BRIEF.md
# DDR2 Bank Timing Guard

This block watches a DDR2-style command bus with four banks and flags every command that breaks a bank-state or spacing rule. On each clock it decodes the four active-low control strobes into activate, read, write or precharge. It tracks whether each bank has an open row, and it keeps saturating cycle counters for the spacing rules between those commands. When a command breaks a rule, the block raises a one-cycle violation pulse. The pulse carries a 3-bit code and the bank number.

The block also models two effects of additive latency (AL). First, a read or write may follow an activate earlier than the row-to-column delay, provided that the cycles since the activate plus AL cover that delay. Second, every read produces an internal-issue pulse AL cycles after the external command. A column command with address bit 10 set to an open bank closes that bank on its own, AL+2 cycles after the command. That closing counts as a precharge for the precharge-to-activate rule.

All timing limits are static 4-bit inputs. The block captures them only while reset is held. Every command still updates the bank state and counters even when it is flagged, so the checker follows what the memory would do.

Top module: `ddr2_bank_guard`

## Requirements
- R1: Commands are decoded from {cs_n,ras_n,cas_n,we_n} as follows: 0011 is activate, 0101 is read, 0100 is write and 0010 is precharge. After the clock edge that samples an activate, bank_open[ba] is 1. After the edge that samples a precharge to an open bank, bank_open[ba] is 0.
- R2: A cycle with cs_n high, or with any other strobe encoding, raises no violation and leaves bank_open unchanged.
- R3: A violation appears one cycle after the edge that samples the offending command. At that point viol is 1 for one cycle, viol_code holds the rule and viol_bank holds the command's bank.
- R4: An activate to an open bank reports code 1. A read or write to a closed bank reports code 2.
- R5: A read or write to an open bank reports code 3 when the cycles since that bank's activate, plus AL, are below tRCD.
- R6: A read or write closer than tCCD cycles to the previous read or write on any bank reports code 4.
- R7: A precharge to an open bank earlier than tRAS cycles after its activate reports code 5.
- R8: An activate to a closed bank reports code 6 when it comes under tRP cycles after the bank's precharge. Otherwise it reports code 7 when it comes under tRC cycles after the bank's previous activate. Otherwise it reports code 0 when it comes under tRRD cycles after the previous activate to any bank. Only the first failing rule in this order is reported, and code 1 outranks all three. For reads and writes, code 2 outranks 3, and 3 outranks 4.
- R9: A read or write with addr[10]=1 to an open bank clears that bank's open flag AL+2 cycles after the command's edge. The tRP interval is counted from that closing edge.
- R10: rd_issue pulses, with rd_issue_bank set to the command's bank, AL cycles after the edge of each decoded read. With AL=0 the pulse comes on the same cycle as the violation result. Writes produce no pulse.
- R11: The timing inputs and AL are captured only while rst_n is low. An AL input above 6 acts as 6.
- R12: In reset, bank_open is 0 and viol is 0. All interval counters start saturated, so the first commands after reset meet every timing rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; configuration is captured while low |
| cs_n | input | 1 | Chip select strobe, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write-enable strobe, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Row/column address; bit 10 requests auto-precharge on a column command |
| cfg_trcd | input | 4 | Minimum activate-to-column cycles |
| cfg_tras | input | 4 | Minimum activate-to-precharge cycles |
| cfg_trp | input | 4 | Minimum precharge-to-activate cycles |
| cfg_trc | input | 4 | Minimum activate-to-activate cycles, same bank |
| cfg_trrd | input | 4 | Minimum activate-to-activate cycles, any bank |
| cfg_tccd | input | 4 | Minimum column-to-column cycles |
| cfg_al | input | 3 | Additive latency, 0 to 6 |
| viol | output | 1 | One-cycle violation pulse |
| viol_code | output | 3 | Rule that was broken |
| viol_bank | output | 2 | Bank of the offending command |
| bank_open | output | 4 | Open-row flag per bank |
| rd_issue | output | 1 | Internal read issue pulse |
| rd_issue_bank | output | 2 | Bank of the internally issued read |

## Verification
A wrong bank flag shows up at bank_open on the very next cycle. On the next command to that bank, it also produces a spurious code 1 or 2, or a missing one. A counter that is loaded late or saturates wrongly moves the boundary of a rule by one cycle, so the bench places commands exactly at and one short of each limit and reads viol_code one cycle later. An auto-precharge countdown or issue pipe that is off by one shows up as bank_open[2] falling, or rd_issue rising, one cycle early or late. The bench checks both against the AL+2 and AL distances.

// File: rtl/ddr2_guard_pkg.sv
package ddr2_guard_pkg;

  parameter int CNT_W = 4;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  typedef enum logic [2:0] {
    V_RRD        = 3'd0,
    V_ACT_OPEN   = 3'd1,
    V_COL_CLOSED = 3'd2,
    V_RCD        = 3'd3,
    V_CCD        = 3'd4,
    V_RAS        = 3'd5,
    V_RP         = 3'd6,
    V_RC         = 3'd7
  } viol_e;

  // Strobe decode; a deselected chip is always a no-op.
  function automatic cmd_e decode_cmd(input logic cs, input logic ras,
                                      input logic cas, input logic we);
    case ({cs, ras, cas, we})
      4'b0011: return CMD_ACT;
      4'b0101: return CMD_RD;
      4'b0100: return CMD_WR;
      4'b0010: return CMD_PRE;
      default: return CMD_NOP;
    endcase
  endfunction

  // Saturating increment: all-ones means "long ago".
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (&v) ? v : v + CNT_W'(1);
  endfunction

  function automatic logic gap_met(input logic [CNT_W-1:0] since,
                                   input logic [CNT_W-1:0] min_gap);
    return since >= min_gap;
  endfunction

  // Posted column command: elapsed cycles plus additive latency must cover tRCD.
  function automatic logic rcd_met(input logic [CNT_W-1:0] since,
                                   input logic [CNT_W-1:0] al,
                                   input logic [CNT_W-1:0] trcd);
    return ({1'b0, since} + {1'b0, al}) >= {1'b0, trcd};
  endfunction

endpackage

// File: rtl/ddr2_bank_slot.sv
module ddr2_bank_slot
  import ddr2_guard_pkg::*;
#(
  parameter int AP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act,
  input  logic             pre,
  input  logic             ap_req,
  input  logic [AP_W-1:0]  ap_len,
  output logic             is_open,
  output logic             close_evt,
  output logic [CNT_W-1:0] since_act,
  output logic [CNT_W-1:0] since_pre
);

  logic [AP_W-1:0] ap_cnt;
  logic            ap_start;

  assign close_evt = (ap_cnt == AP_W'(1));
  // Auto-precharge is only armed on a bank that is open and not already closing.
  assign ap_start  = ap_req && is_open && !close_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open   <= 1'b0;
      ap_cnt    <= '0;
      since_act <= '1;
      since_pre <= '1;
    end else begin
      since_act <= act ? CNT_W'(1) : sat_inc(since_act);
      since_pre <= ((pre && is_open) || close_evt) ? CNT_W'(1) : sat_inc(since_pre);
      if (act)                   is_open <= 1'b1;
      else if (pre || close_evt) is_open <= 1'b0;
      if (ap_start)              ap_cnt <= ap_len;
      else if (act || pre)       ap_cnt <= '0;
      else if (ap_cnt != '0)     ap_cnt <= ap_cnt - AP_W'(1);
    end
  end

endmodule

// File: rtl/ddr2_issue_pipe.sv
module ddr2_issue_pipe #(
  parameter int MAX_AL = 6,
  parameter int BANK_W = 2,
  parameter int AL_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_in,
  input  logic [BANK_W-1:0] bank_in,
  input  logic [AL_W-1:0]   al,
  output logic              issue,
  output logic [BANK_W-1:0] issue_bank
);

  logic [MAX_AL:0]   stg_v;
  logic [BANK_W-1:0] stg_b [MAX_AL+1];

  always_ff @(posedge clk) begin
    if (!rst_n) stg_v <= '0;
    else        stg_v <= {stg_v[MAX_AL-1:0], rd_in};
  end

  always_ff @(posedge clk) begin
    stg_b[0] <= bank_in;
    for (int i = 1; i <= MAX_AL; i++) stg_b[i] <= stg_b[i-1];
  end

  // Tap AL selects the delay; tap 0 is one register after the command edge.
  assign issue      = stg_v[al];
  assign issue_bank = stg_b[al];

endmodule

// File: rtl/ddr2_bank_guard.sv
module ddr2_bank_guard
  import ddr2_guard_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int AP_BIT    = 10,
  parameter int MAX_AL    = 6,
  parameter int BURST_CYC = 2,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int AL_W     = $clog2(MAX_AL + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BANK_W-1:0]    ba,
  input  logic [ROW_W-1:0]     addr,
  input  logic [CNT_W-1:0]     cfg_trcd,
  input  logic [CNT_W-1:0]     cfg_tras,
  input  logic [CNT_W-1:0]     cfg_trp,
  input  logic [CNT_W-1:0]     cfg_trc,
  input  logic [CNT_W-1:0]     cfg_trrd,
  input  logic [CNT_W-1:0]     cfg_tccd,
  input  logic [AL_W-1:0]      cfg_al,
  output logic                 viol,
  output logic [2:0]           viol_code,
  output logic [BANK_W-1:0]    viol_bank,
  output logic [NUM_BANKS-1:0] bank_open,
  output logic                 rd_issue,
  output logic [BANK_W-1:0]    rd_issue_bank
);

  localparam int AP_W = $clog2(MAX_AL + BURST_CYC + 1);

  // Static configuration, captured in reset only.
  logic [CNT_W-1:0] trcd_q, tras_q, trp_q, trc_q, trrd_q, tccd_q;
  logic [AL_W-1:0]  cfg_al_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trcd_q   <= cfg_trcd;
      tras_q   <= cfg_tras;
      trp_q    <= cfg_trp;
      trc_q    <= cfg_trc;
      trrd_q   <= cfg_trrd;
      tccd_q   <= cfg_tccd;
      cfg_al_q <= (cfg_al > AL_W'(MAX_AL)) ? AL_W'(MAX_AL) : cfg_al;
    end
  end

  // Decoded command events, named for the checker.
  cmd_e cmd;
  logic cmd_act, cmd_rd, cmd_wr, cmd_col, cmd_pre;
  assign cmd     = decode_cmd(cs_n, ras_n, cas_n, we_n);
  assign cmd_act = (cmd == CMD_ACT);
  assign cmd_rd  = (cmd == CMD_RD);
  assign cmd_wr  = (cmd == CMD_WR);
  assign cmd_col = cmd_rd || cmd_wr;
  assign cmd_pre = (cmd == CMD_PRE);

  logic unused_addr;
  assign unused_addr = ^{addr[ROW_W-1:AP_BIT+1], addr[AP_BIT-1:0]};

  logic [AP_W-1:0]      ap_len;
  assign ap_len = AP_W'(cfg_al_q) + AP_W'(BURST_CYC);

  logic [NUM_BANKS-1:0] open_v, close_evt;
  logic [CNT_W-1:0]     since_act [NUM_BANKS];
  logic [CNT_W-1:0]     since_pre [NUM_BANKS];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic hit;
    assign hit = (ba == BANK_W'(g));
    ddr2_bank_slot #(.AP_W(AP_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .act       (cmd_act && hit),
      .pre       (cmd_pre && hit),
      .ap_req    (cmd_col && addr[AP_BIT] && hit),
      .ap_len    (ap_len),
      .is_open   (open_v[g]),
      .close_evt (close_evt[g]),
      .since_act (since_act[g]),
      .since_pre (since_pre[g])
    );
  end

  // Bus-wide spacing counters.
  logic [CNT_W-1:0] since_any_act, since_col;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_any_act <= '1;
      since_col     <= '1;
    end else begin
      since_any_act <= cmd_act ? CNT_W'(1) : sat_inc(since_any_act);
      since_col     <= cmd_col ? CNT_W'(1) : sat_inc(since_col);
    end
  end

  // Rule evaluation, first failing rule wins.
  logic  v_hit;
  viol_e v_code;
  logic  sel_open;
  assign sel_open = open_v[ba];

  always_comb begin
    v_hit  = 1'b1;
    v_code = V_RRD;
    unique case (1'b1)
      cmd_act: begin
        if (sel_open)                              v_code = V_ACT_OPEN;
        else if (!gap_met(since_pre[ba], trp_q))   v_code = V_RP;
        else if (!gap_met(since_act[ba], trc_q))   v_code = V_RC;
        else if (!gap_met(since_any_act, trrd_q))  v_code = V_RRD;
        else                                       v_hit  = 1'b0;
      end
      cmd_col: begin
        if (!sel_open)                                          v_code = V_COL_CLOSED;
        else if (!rcd_met(since_act[ba], CNT_W'(cfg_al_q), trcd_q)) v_code = V_RCD;
        else if (!gap_met(since_col, tccd_q))                   v_code = V_CCD;
        else                                                    v_hit  = 1'b0;
      end
      cmd_pre: begin
        if (sel_open && !gap_met(since_act[ba], tras_q)) v_code = V_RAS;
        else                                             v_hit  = 1'b0;
      end
      default: v_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol      <= 1'b0;
      viol_code <= '0;
      viol_bank <= '0;
    end else begin
      viol      <= v_hit;
      viol_code <= v_hit ? v_code : 3'd0;
      viol_bank <= ba;
    end
  end

  assign bank_open = open_v;

  ddr2_issue_pipe #(.MAX_AL(MAX_AL), .BANK_W(BANK_W), .AL_W(AL_W)) u_issue (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_in      (cmd_rd),
    .bank_in    (ba),
    .al         (cfg_al_q),
    .issue      (rd_issue),
    .issue_bank (rd_issue_bank)
  );

endmodule

// File: rtl/ddr2_bank_guard_chk.sv
module ddr2_bank_guard_chk #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int AL_W      = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [BANK_W-1:0]    ba,
  input logic                 cmd_act,
  input logic                 cmd_rd,
  input logic                 cmd_col,
  input logic                 cmd_pre,
  input logic [NUM_BANKS-1:0] close_evt,
  input logic [AL_W-1:0]      cfg_al_q,
  input logic                 viol,
  input logic [2:0]           viol_code,
  input logic [BANK_W-1:0]    viol_bank,
  input logic [NUM_BANKS-1:0] bank_open,
  input logic                 rd_issue
);

  assert_act_opens_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_act |=> bank_open[$past(ba)]);

  assert_pre_closes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pre |=> !bank_open[$past(ba)]);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_act && !cmd_col && !cmd_pre && close_evt == '0) |=> ($stable(bank_open) && !viol));

  assert_viol_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> (viol_bank == $past(ba)));

  assert_act_open_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_act && bank_open[ba]) |=> (viol && viol_code == 3'd1));

  assert_col_closed_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_col && !bank_open[ba]) |=> (viol && viol_code == 3'd2));

  assert_issue_no_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rd && cfg_al_q == '0) |=> rd_issue);

endmodule

bind ddr2_bank_guard ddr2_bank_guard_chk #(
  .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .AL_W(AL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ba        (ba),
  .cmd_act   (cmd_act),
  .cmd_rd    (cmd_rd),
  .cmd_col   (cmd_col),
  .cmd_pre   (cmd_pre),
  .close_evt (close_evt),
  .cfg_al_q  (cfg_al_q),
  .viol      (viol),
  .viol_code (viol_code),
  .viol_bank (viol_bank),
  .bank_open (bank_open),
  .rd_issue  (rd_issue)
);

// File: tb/ddr2_bank_guard_bench.sv
module ddr2_bank_guard_bench;

  localparam int CLK_NS = 8;
  localparam int K_NOP = 0, K_ACT = 1, K_RD = 2, K_WR = 3, K_PRE = 4, K_DESEL = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;
  logic [3:0]  cfg_trcd = 4'd3, cfg_tras = 4'd4, cfg_trp = 4'd3;
  logic [3:0]  cfg_trc = 4'd7, cfg_trrd = 4'd2, cfg_tccd = 4'd2;
  logic [2:0]  cfg_al = 3'd2;
  logic        viol, rd_issue;
  logic [2:0]  viol_code;
  logic [1:0]  viol_bank, rd_issue_bank;
  logic [3:0]  bank_open;

  always #(CLK_NS/2) clk = ~clk;

  ddr2_bank_guard u_ddr2_bank_guard (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .cfg_trcd(cfg_trcd), .cfg_tras(cfg_tras), .cfg_trp(cfg_trp),
    .cfg_trc(cfg_trc), .cfg_trrd(cfg_trrd), .cfg_tccd(cfg_tccd), .cfg_al(cfg_al),
    .viol(viol), .viol_code(viol_code), .viol_bank(viol_bank), .bank_open(bank_open),
    .rd_issue(rd_issue), .rd_issue_bank(rd_issue_bank)
  );

  typedef struct {
    int    n;
    bit    exp_viol;
    int    code;
    int    bank;
    bit    exp_issue;
    int    ibank;
    string req;
  } exp_t;

  exp_t  sb_q[$];
  bit    sched_v[int];
  int    sched_b[int];
  int    n_idx = 0;
  int    cur_al = 2;
  int    checks = 0;
  int    fails = 0;
  bit    done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Driver: one bus cycle, expected result pushed to the scoreboard. code < 0 means legal.
  task automatic drive(input int kind, input int b, input bit a10, input int code,
                       input string req);
    exp_t e;
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = 4'b1111;
    case (kind)
      K_ACT:   {cs_n, ras_n, cas_n, we_n} = 4'b0011;
      K_RD:    {cs_n, ras_n, cas_n, we_n} = 4'b0101;
      K_WR:    {cs_n, ras_n, cas_n, we_n} = 4'b0100;
      K_PRE:   {cs_n, ras_n, cas_n, we_n} = 4'b0010;
      K_DESEL: {cs_n, ras_n, cas_n, we_n} = 4'b1011;
      default: {cs_n, ras_n, cas_n, we_n} = 4'b0111;
    endcase
    ba   = 2'(b);
    addr = a10 ? 13'h04A5 : 13'h00A5;
    if (kind == K_RD) begin
      sched_v[n_idx + cur_al] = 1'b1;
      sched_b[n_idx + cur_al] = b;
    end
    e.n         = n_idx;
    e.exp_viol  = (code >= 0);
    e.code      = code;
    e.bank      = b;
    e.exp_issue = sched_v.exists(n_idx) ? sched_v[n_idx] : 1'b0;
    e.ibank     = sched_b.exists(n_idx) ? sched_b[n_idx] : 0;
    e.req       = req;
    sb_q.push_back(e);
    n_idx++;
  endtask

  task automatic peek_open(input logic [3:0] exp, input string req);
    @(posedge clk);
    #3;
    chk(bank_open == exp, req, "bank_open", int'(bank_open), int'(exp));
  endtask

  task automatic do_reset(input logic [3:0] trcd, input logic [2:0] al, input int eff_al);
    @(negedge clk);
    rst_n = 1'b0;
    {cs_n, ras_n, cas_n, we_n} = 4'b1111;
    cfg_trcd = trcd;
    cfg_al   = al;
    repeat (3) @(negedge clk);
    chk(bank_open == 4'b0000, "R12", "bank_open in reset", int'(bank_open), 0);
    chk(viol == 1'b0, "R12", "viol in reset", int'(viol), 0);
    rst_n  = 1'b1;
    cur_al = eff_al;
  endtask

  // Monitor: compares each bus cycle's registered result, after its edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        chk(viol == e.exp_viol, e.req, $sformatf("viol cycle %0d", e.n), int'(viol), int'(e.exp_viol));
        if (e.exp_viol && viol) begin
          chk(int'(viol_code) == e.code, e.req, $sformatf("viol_code cycle %0d", e.n),
              int'(viol_code), e.code);
          chk(int'(viol_bank) == e.bank, "R3", $sformatf("viol_bank cycle %0d", e.n),
              int'(viol_bank), e.bank);
        end
        chk(rd_issue == e.exp_issue, "R10", $sformatf("rd_issue cycle %0d", e.n),
            int'(rd_issue), int'(e.exp_issue));
        if (e.exp_issue && rd_issue)
          chk(int'(rd_issue_bank) == e.ibank, "R10", $sformatf("rd_issue_bank cycle %0d", e.n),
              int'(rd_issue_bank), e.ibank);
      end
    end
  end

  initial begin
    #(CLK_NS * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // Configuration A: tRCD=3 AL=2 tRAS=4 tRP=3 tRC=7 tRRD=2 tCCD=2
    do_reset(4'd3, 3'd2, 2);
    drive(K_ACT, 0, 0, -1, "R12");          // n0: counters saturated, legal
    peek_open(4'b0001, "R1");
    drive(K_RD,  0, 0, -1, "R5");           // n1: 1+AL=3 meets tRCD, posted read
    drive(K_ACT, 1, 0, -1, "R8");           // n2: exactly tRRD
    drive(K_WR,  1, 0, -1, "R6");           // n3: exactly tCCD, write gives no issue
    drive(K_RD,  1, 0, 4, "R6");            // n4: tCCD short by one
    drive(K_PRE, 0, 0, -1, "R7");           // n5: tRAS met
    peek_open(4'b0010, "R1");
    drive(K_ACT, 0, 0, 6, "R8");            // n6: tRP and tRC both short, tRP wins
    drive(K_ACT, 2, 0, 0, "R8");            // n7: tRRD short
    drive(K_ACT, 2, 0, 1, "R4");            // n8: bank already open (outranks tRRD)
    drive(K_PRE, 2, 0, 5, "R7");            // n9: tRAS short
    drive(K_RD,  3, 0, 2, "R4");            // n10: closed bank
    drive(K_NOP, 0, 0, -1, "R2");
    drive(K_NOP, 0, 0, -1, "R2");
    peek_open(4'b0011, "R2");
    drive(K_ACT, 2, 0, 7, "R8");            // n13: tRP met, tRC short
    drive(K_NOP, 0, 0, -1, "R2");
    drive(K_NOP, 0, 0, -1, "R2");
    drive(K_RD,  2, 1, -1, "R9");           // n16: auto-precharge read
    drive(K_NOP, 0, 0, -1, "R9");
    drive(K_NOP, 0, 0, -1, "R9");
    drive(K_NOP, 0, 0, -1, "R9");
    peek_open(4'b0111, "R9");               // AL+2-1 edges later: still open
    drive(K_NOP, 0, 0, -1, "R9");
    peek_open(4'b0011, "R9");               // AL+2 edges later: closed
    drive(K_ACT, 2, 0, 6, "R9");            // tRP counted from the self-close
    drive(K_NOP, 0, 0, -1, "R2");
    drive(K_NOP, 0, 0, -1, "R2");
    drive(K_NOP, 0, 0, -1, "R2");

    // Configuration B: AL=0; inputs changed after reset must be ignored
    do_reset(4'd3, 3'd0, 0);
    cfg_al   = 3'd6;
    cfg_trcd = 4'd15;
    drive(K_ACT, 1, 0, -1, "R11");
    drive(K_RD,  1, 0, 3, "R5");            // 1+0 < tRCD, issue same cycle as result
    drive(K_NOP, 0, 0, -1, "R2");
    drive(K_RD,  1, 0, -1, "R11");          // 3+0 meets captured tRCD=3
    drive(K_DESEL, 2, 0, -1, "R2");         // activate strobes with cs_n high
    peek_open(4'b0010, "R2");
    drive(K_NOP, 0, 0, -1, "R2");

    // Configuration C: AL input 7 acts as 6
    do_reset(4'd3, 3'd7, 6);
    drive(K_ACT, 0, 0, -1, "R11");
    drive(K_RD,  0, 0, -1, "R11");
    for (int i = 0; i < 8; i++) drive(K_NOP, 0, 0, -1, "R10");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule